// File: doc/BRIEF.md
# Variable-length instruction decoder

This block is the combinational front end of a small 32-bit processor. Fetch hands it six bytes read at the current program counter. From the first byte alone it settles the instruction's class, its operation selector and its length of one, two or six bytes. It then pulls out the register-pair byte and a 32-bit constant stored least significant byte first. Finally it forms the address of the following instruction.

The covered set is small: stop, idle, four register moves (register to register, constant to register, register to memory, memory to register) and four arithmetic/logic operations. Any byte pattern outside that set raises an invalid-instruction flag. The following stages use that flag to stop the machine, and the decoder squashes its other decoded fields when it is set. Branches, calls, returns, stack operations and the memory access itself belong to other blocks.

Top module: `instdec_top`

## Requirements
- R1: `opClass` equals bits 7:4 of window byte 0 and `opFunc` equals bits 3:0 of window byte 0, whatever their value. Window byte k sits at `instWindow[8k+7:8k]`.
- R2: For a valid instruction, `instLen` is 1 for classes 0 (stop) and 1 (idle), 2 for classes 2 (register move) and 6 (arithmetic), and 6 for classes 3 (constant move), 4 (store move) and 5 (load move). `nextPc` equals `fetchPc + instLen` modulo 2^32.
- R3: For classes 2 to 6, `regA` is bits 7:4 and `regB` is bits 3:0 of window byte 1. For classes 0 and 1 both read 4'hF.
- R4: For classes 3, 4 and 5, `constVal` is window bytes 2..5 joined little-endian, with byte 2 as the least significant byte. For every other class `constVal` is 0.
- R5: Class 6 accepts function codes 0 (add), 1 (subtract), 2 (and) and 3 (xor). Function codes 4 to 15 in class 6 raise `badInstr`.
- R6: Classes 2, 3, 4 and 5 accept only function code 0. Any other function code raises `badInstr`.
- R7: Classes 7 to 15 always raise `badInstr`.
- R8: A class 3 instruction whose byte 1 high nibble is not 4'hF raises `badInstr`.
- R9: While `badInstr` is 1: `instLen` is 0, `nextPc` equals `fetchPc`, `regA` and `regB` are 4'hF, and `constVal` is 0.
- R10: Classes 0 and 1 are valid with any function code. Window bytes 1..5 have no effect on `regA`, `regB`, `constVal`, `instLen` or `badInstr` for these classes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fetchPc | input | 32 | Address the window was fetched from |
| instWindow | input | 48 | Six fetched bytes, byte 0 in bits 7:0 |
| opClass | output | 4 | Instruction class nibble |
| opFunc | output | 4 | Function selector nibble |
| regA | output | 4 | First register identifier, 4'hF if absent |
| regB | output | 4 | Second register identifier, 4'hF if absent |
| constVal | output | 32 | Little-endian constant, 0 if absent |
| instLen | output | 3 | Instruction length in bytes, 0 when invalid |
| nextPc | output | 32 | Address of the following instruction |
| badInstr | output | 1 | Invalid-instruction status |

## Verification
Directed windows cover each class in turn. Filler bytes are placed after the short encodings, so that a length or constant taken from the wrong lane shows up as a non-zero constant or a wrong next address. The constant windows use asymmetric byte values (0x12345678, 0xfffffffc, 0xabcd) to separate true little-endian assembly from a byte-swapped or shifted one. Near-miss patterns — function code 4 in the arithmetic class, a non-zero function code on a move, a missing 0xF in the constant move, an unused class — probe the legality boundary. A program counter near the top of the address space checks that the next address wraps.

// File: rtl/instdec_pkg.sv
package instdec_pkg;

  localparam int WIN_BYTES = 6;
  localparam int ADDR_W    = 32;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = $clog2(WIN_BYTES + 1);
  localparam int CONST_OFS = 2;
  localparam logic [3:0] NO_REG = 4'hF;

  typedef enum logic [3:0] {
    OP_STOP  = 4'h0,
    OP_IDLE  = 4'h1,
    OP_MOVRR = 4'h2,
    OP_MOVIR = 4'h3,
    OP_MOVRM = 4'h4,
    OP_MOVMR = 4'h5,
    OP_ARITH = 4'h6
  } opClass_e;

  localparam logic [3:0] ARITH_MAX_FN = 4'h3;

  typedef struct packed {
    logic             legal;
    logic             useRegs;
    logic             useConst;
    logic [LEN_W-1:0] lenBytes;
  } decStrobes_t;

endpackage

// File: rtl/instdec_ctrl.sv
module instdec_ctrl
  import instdec_pkg::*;
(
  input  logic [7:0]  opByte,
  input  logic [3:0]  regHiNibble,
  output decStrobes_t strobes
);

  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_PAIR  = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(WIN_BYTES);

  logic [3:0] classNib;
  logic [3:0] funcNib;
  logic       funcZero;
  logic       funcArithOk;

  assign classNib    = opByte[7:4];
  assign funcNib     = opByte[3:0];
  assign funcZero    = (funcNib == 4'h0);
  assign funcArithOk = (funcNib <= ARITH_MAX_FN);

  decStrobes_t raw;

  always_comb begin
    raw = '0;
    unique case (classNib)
      OP_STOP, OP_IDLE: begin
        raw.legal    = 1'b1;
        raw.lenBytes = LEN_SHORT;
      end
      OP_MOVRR: begin
        raw.legal    = funcZero;
        raw.useRegs  = 1'b1;
        raw.lenBytes = LEN_PAIR;
      end
      OP_MOVIR: begin
        raw.legal    = funcZero && (regHiNibble == NO_REG);
        raw.useRegs  = 1'b1;
        raw.useConst = 1'b1;
        raw.lenBytes = LEN_LONG;
      end
      OP_MOVRM, OP_MOVMR: begin
        raw.legal    = funcZero;
        raw.useRegs  = 1'b1;
        raw.useConst = 1'b1;
        raw.lenBytes = LEN_LONG;
      end
      OP_ARITH: begin
        raw.legal    = funcArithOk;
        raw.useRegs  = 1'b1;
        raw.lenBytes = LEN_PAIR;
      end
      default: raw = '0;
    endcase
  end

  // Squash every strobe of an illegal instruction in one place.
  always_comb begin
    if (raw.legal) strobes = raw;
    else           strobes = '0;
  end

endmodule

// File: rtl/instdec_datapath.sv
module instdec_datapath
  import instdec_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int WORD_BITS = WORD_W,
  parameter int WIN_N     = WIN_BYTES
) (
  input  logic [ADDR_BITS-1:0] fetchPc,
  input  logic [WIN_N*8-1:0]   instWindow,
  input  decStrobes_t          strobes,
  output logic [3:0]           regA,
  output logic [3:0]           regB,
  output logic [WORD_BITS-1:0] constVal,
  output logic [LEN_W-1:0]     instLen,
  output logic [ADDR_BITS-1:0] nextPc
);

  localparam int CONST_BYTES = WORD_BITS / 8;
  localparam int PAD_W       = ADDR_BITS - LEN_W;

  logic [7:0]           regByte;
  logic [WORD_BITS-1:0] rawConst;

  assign regByte = instWindow[15:8];

  // Little-endian assembly: lane k of the constant comes from window byte CONST_OFS+k.
  for (genvar k = 0; k < CONST_BYTES; k++) begin : g_constLane
    assign rawConst[8*k +: 8] = instWindow[8*(CONST_OFS+k) +: 8];
  end

  always_comb begin
    if (strobes.useRegs) begin
      regA = regByte[7:4];
      regB = regByte[3:0];
    end else begin
      regA = NO_REG;
      regB = NO_REG;
    end
  end

  assign constVal = strobes.useConst ? rawConst : '0;
  assign instLen  = strobes.lenBytes;
  assign nextPc   = fetchPc + {{PAD_W{1'b0}}, strobes.lenBytes};

endmodule

// File: rtl/instdec_top.sv
module instdec_top
  import instdec_pkg::*;
(
  input  logic [31:0] fetchPc,
  input  logic [47:0] instWindow,
  output logic [3:0]  opClass,
  output logic [3:0]  opFunc,
  output logic [3:0]  regA,
  output logic [3:0]  regB,
  output logic [31:0] constVal,
  output logic [2:0]  instLen,
  output logic [31:0] nextPc,
  output logic        badInstr
);

  decStrobes_t strobes;

  assign opClass = instWindow[7:4];
  assign opFunc  = instWindow[3:0];

  instdec_ctrl ctrl_i (
    .opByte      (instWindow[7:0]),
    .regHiNibble (instWindow[15:12]),
    .strobes     (strobes)
  );

  instdec_datapath #(
    .ADDR_BITS (ADDR_W),
    .WORD_BITS (WORD_W),
    .WIN_N     (WIN_BYTES)
  ) dp_i (
    .fetchPc    (fetchPc),
    .instWindow (instWindow),
    .strobes    (strobes),
    .regA       (regA),
    .regB       (regB),
    .constVal   (constVal),
    .instLen    (instLen),
    .nextPc     (nextPc)
  );

  assign badInstr = ~strobes.legal;

endmodule

// File: rtl/instdec_checker.sv
module instdec_checker (
  input logic [31:0] fetchPc,
  input logic [47:0] instWindow,
  input logic [3:0]  opClass,
  input logic [3:0]  regA,
  input logic [3:0]  regB,
  input logic [31:0] constVal,
  input logic [2:0]  instLen,
  input logic [31:0] nextPc,
  input logic        badInstr
);

  always_comb begin
    a_r2_len_legal: assert (instLen == 3'd0 || instLen == 3'd1 || instLen == 3'd2 || instLen == 3'd6)
      else $error("instLen out of set: %0d", instLen);
    a_r2_next_pc: assert (nextPc == fetchPc + {29'd0, instLen})
      else $error("nextPc does not follow length");
    a_r7_undefined_class: assert (!(instWindow[7:4] > 4'h6) || badInstr)
      else $error("undefined class accepted");
    a_r8_const_move_marker: assert (!(instWindow[7:4] == 4'h3 && instWindow[15:12] != 4'hF) || badInstr)
      else $error("constant move without marker accepted");
    a_r9_squash: assert (!badInstr || (instLen == 3'd0 && regA == 4'hF && regB == 4'hF && constVal == 32'd0))
      else $error("invalid instruction not squashed");
    a_r10_short_clean: assert (!(opClass < 4'h2) || (!badInstr && regA == 4'hF && regB == 4'hF && constVal == 32'd0 && instLen == 3'd1))
      else $error("one-byte class decoded wrongly");
  end

endmodule

bind instdec_top instdec_checker chk_i (
  .fetchPc    (fetchPc),
  .instWindow (instWindow),
  .opClass    (opClass),
  .regA       (regA),
  .regB       (regB),
  .constVal   (constVal),
  .instLen    (instLen),
  .nextPc     (nextPc),
  .badInstr   (badInstr)
);

// File: tb/instdec_tb_top.sv
`timescale 1ns/1ps
module instdec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic [47:0] instWindow = '0;
  logic [3:0]  opClass, opFunc, regA, regB;
  logic [31:0] constVal, nextPc;
  logic [2:0]  instLen;
  logic        badInstr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  instdec_top dut_i (
    .fetchPc(fetchPc), .instWindow(instWindow), .opClass(opClass), .opFunc(opFunc),
    .regA(regA), .regB(regB), .constVal(constVal), .instLen(instLen),
    .nextPc(nextPc), .badInstr(badInstr)
  );

  function automatic logic [47:0] mkWin(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] pc, input logic [47:0] win);
    @(negedge clk);
    fetchPc = pc;
    instWindow = win;
    #1;
  endtask

  // Full check of all decoded outputs for one window.
  task automatic expectAll(input string req, input logic [3:0] eCls, eFn, eA, eB,
                           input logic [31:0] eConst, input logic [2:0] eLen,
                           input logic [31:0] eNext, input logic eBad);
    check(req, "opClass", {28'd0, opClass}, {28'd0, eCls});
    check(req, "opFunc", {28'd0, opFunc}, {28'd0, eFn});
    check(req, "regA", {28'd0, regA}, {28'd0, eA});
    check(req, "regB", {28'd0, regB}, {28'd0, eB});
    check(req, "constVal", constVal, eConst);
    check(req, "instLen", {29'd0, instLen}, {29'd0, eLen});
    check(req, "nextPc", nextPc, eNext);
    check(req, "badInstr", {31'd0, badInstr}, {31'd0, eBad});
  endtask

  task automatic testResetState();
    apply(32'h0, 48'h0);
    expectAll("R1 reset stop", 4'h0, 4'h0, 4'hF, 4'hF, 32'h0, 3'd1, 32'h1, 1'b0);
  endtask

  task automatic testShortClasses();
    apply(32'h40, mkWin(8'h07, 8'hFF, 8'h12, 8'h34, 8'h56, 8'h78));
    expectAll("R10 stop junk", 4'h0, 4'h7, 4'hF, 4'hF, 32'h0, 3'd1, 32'h41, 1'b0);
    apply(32'h100, mkWin(8'h1A, 8'h23, 8'h99, 8'h88, 8'h77, 8'h66));
    expectAll("R10 idle", 4'h1, 4'hA, 4'hF, 4'hF, 32'h0, 3'd1, 32'h101, 1'b0);
  endtask

  task automatic testArith();
    apply(32'h200, mkWin(8'h60, 8'h06, 8'hDE, 8'hAD, 8'hBE, 8'hEF));
    expectAll("R3 R4 add", 4'h6, 4'h0, 4'h0, 4'h6, 32'h0, 3'd2, 32'h202, 1'b0);
    apply(32'h210, mkWin(8'h63, 8'h37, 8'h00, 8'h00, 8'h00, 8'h00));
    expectAll("R5 xor", 4'h6, 4'h3, 4'h3, 4'h7, 32'h0, 3'd2, 32'h212, 1'b0);
    apply(32'h220, mkWin(8'h64, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00));
    expectAll("R5 R9 fn4", 4'h6, 4'h4, 4'hF, 4'hF, 32'h0, 3'd0, 32'h220, 1'b1);
  endtask

  task automatic testRegMove();
    apply(32'h300, mkWin(8'h20, 8'h45, 8'h11, 8'h22, 8'h33, 8'h44));
    expectAll("R2 R3 rr move", 4'h2, 4'h0, 4'h4, 4'h5, 32'h0, 3'd2, 32'h302, 1'b0);
    apply(32'h310, mkWin(8'h21, 8'h45, 8'h00, 8'h00, 8'h00, 8'h00));
    expectAll("R6 rr fn1", 4'h2, 4'h1, 4'hF, 4'hF, 32'h0, 3'd0, 32'h310, 1'b1);
  endtask

  task automatic testConstMoves();
    apply(32'h10, mkWin(8'h30, 8'hF2, 8'hCD, 8'hAB, 8'h00, 8'h00));
    expectAll("R4 R8 const move", 4'h3, 4'h0, 4'hF, 4'h2, 32'h0000ABCD, 3'd6, 32'h16, 1'b0);
    apply(32'h20, mkWin(8'h30, 8'h12, 8'hCD, 8'hAB, 8'h00, 8'h00));
    expectAll("R8 no marker", 4'h3, 4'h0, 4'hF, 4'hF, 32'h0, 3'd0, 32'h20, 1'b1);
    apply(32'h400, mkWin(8'h40, 8'h13, 8'h78, 8'h56, 8'h34, 8'h12));
    expectAll("R4 store move", 4'h4, 4'h0, 4'h1, 4'h3, 32'h12345678, 3'd6, 32'h406, 1'b0);
    apply(32'h500, mkWin(8'h50, 8'h70, 8'hFC, 8'hFF, 8'hFF, 8'hFF));
    expectAll("R4 load move", 4'h5, 4'h0, 4'h7, 4'h0, 32'hFFFFFFFC, 3'd6, 32'h506, 1'b0);
    apply(32'h510, mkWin(8'h52, 8'h70, 8'hFC, 8'hFF, 8'hFF, 8'hFF));
    expectAll("R6 load fn2", 4'h5, 4'h2, 4'hF, 4'hF, 32'h0, 3'd0, 32'h510, 1'b1);
  endtask

  task automatic testUndefined();
    apply(32'h600, mkWin(8'h70, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04));
    expectAll("R7 class7", 4'h7, 4'h0, 4'hF, 4'hF, 32'h0, 3'd0, 32'h600, 1'b1);
    apply(32'h610, mkWin(8'hF0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF));
    expectAll("R7 R9 classF", 4'hF, 4'h0, 4'hF, 4'hF, 32'h0, 3'd0, 32'h610, 1'b1);
  endtask

  task automatic testWrap();
    apply(32'hFFFFFFFC, mkWin(8'h30, 8'hF1, 8'h01, 8'h00, 8'h00, 8'h80));
    expectAll("R2 wrap", 4'h3, 4'h0, 4'hF, 4'h1, 32'h80000001, 3'd6, 32'h00000002, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testResetState();
    testShortClasses();
    testArith();
    testRegMove();
    testConstMoves();
    testUndefined();
    testWrap();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule